// File: doc/BRIEF.md
# Programmable Interval Timer

A down-counting interval timer behind a small word-addressed register bus. Software loads a reload limit, picks periodic or one-shot operation and starts the timer. The count then drops by one per prescaled tick, where one tick is a fixed number of clock cycles. When a tick finds the count at 1 or below, the timer expires. It latches an interrupt status bit and then either reloads the limit (periodic) or parks at zero and stops itself (one-shot). The interrupt output is a level. It is high while the latched status is set and the enable register is nonzero. Software acknowledges it by writing a 1 to bit 0 of the status register.

The bus is a plain single-cycle register port with no data stream, so it carries no valid/ready handshake. A write takes effect on the clock edge where `bus_we` is high. Read data is a combinational function of the address and the current register state, and it is valid in the same cycle. The register index is address bits [11:2], and the two low address bits are ignored. Index map: 0 identity, 1 run flag, 2 one-shot mode, 3 limit, 4 live count, 5 interrupt enable, 6 interrupt status, 7 tick frequency. All other indices are unmapped.

Top module: `itmr_top`

## Requirements
- R1: The register index is `bus_addr[11:2]`. Address bits [1:0] do not change which register is read or written.
- R2: Index 0 reads the `DEV_ID` parameter and index 7 reads `CLK_HZ / TICK_DIV`. Writes to either index change nothing.
- R3: Reads of indices 8 and above return 0. Writes to them change no register.
- R4: After reset, the run flag, mode, limit, count, enable and status all read 0 and `irq` is low.
- R5: While running, the count falls by one every `TICK_DIV` cycles. The first decrement comes on the `TICK_DIV`-th clock edge after the edge that started the timer.
- R6: The run flag holds 1 when the last effective write was nonzero. A write whose zero/nonzero state matches the flag has no effect and does not disturb the tick phase. Writing 0 stops the count, and the count keeps its value.
- R7: In periodic mode, a tick that finds the count at 1 or below sets the status bit and reloads the limit. With limit L the timer expires every L ticks.
- R8: In one-shot mode (mode register nonzero, read back as 1), that same tick sets the status bit, leaves the count at 0 and clears the run flag.
- R9: A mode write while running restarts the tick phase, so the next decrement comes `TICK_DIV` edges later, in the new mode. A mode write while stopped changes only the mode.
- R10: A limit write stores the limit and also loads the count with it. A count write overwrites the count. A bus load in the same cycle as a tick wins, and that tick neither decrements nor expires.
- R11: Writing the status register clears the status bit when data bit 0 is 1 and does nothing when it is 0. An expiry in the same cycle as a clear leaves the status set.
- R12: `irq` is high exactly when the status bit is set and the enable register is nonzero. The enable register reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; bits [11:2] select the register |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
Two pairs of events can land in the same cycle. An expiry can coincide with a status acknowledge, and a tick can coincide with a count load. The bench provokes both by starting the timer on a known edge and counting edges, so that the acknowledge or the count write lands on exactly the edge the prescaler fires. The first case is judged by status still reading 1 and `irq` staying high. The second is judged by the count reading the written value, with status unchanged and the next decrement one full tick period later. Sweeps over several limits in both modes compare the live count and `irq` each cycle against values computed arithmetically from the edge number.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int unsigned IDX_W = 10;

  typedef enum logic [IDX_W-1:0] {
    IX_IDENT  = 10'd0,
    IX_RUN    = 10'd1,
    IX_MODE   = 10'd2,
    IX_LIMIT  = 10'd3,
    IX_COUNT  = 10'd4,
    IX_ENABLE = 10'd5,
    IX_STATUS = 10'd6,
    IX_RATE   = 10'd7
  } reg_ix_e;
endpackage

// File: rtl/itmr_prescale.sv
module itmr_prescale #(
  parameter int unsigned TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  generate
    if (TICK_DIV == 1) begin : g_direct
      assign tick = run && !restart;
    end else begin : g_div
      logic [PW-1:0] phase;
      localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   phase <= '0;
        else if (!run || restart)     phase <= '0;
        else if (phase == LAST)       phase <= '0;
        else                          phase <= phase + 1'b1;
      end

      assign tick = run && !restart && (phase == LAST);

      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R5
    end
  endgenerate
endmodule

// File: rtl/itmr_count.sv
module itmr_count #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         single,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count,
  output logic         expire
);
  logic [W-1:0] nxt;

  assign expire = tick && !load && (count <= W'(1));

  always_comb begin
    nxt = count;
    if (load)          nxt = load_val;
    else if (expire)   nxt = single ? '0 : limit;
    else if (tick)     nxt = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= nxt;
  end

  AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !single) |=> (count == $past(limit))); // R7
  AST_SINGLE_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && single) |=> (count == '0)); // R8
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val))); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count)); // R6
endmodule

// File: rtl/itmr_irq.sv
module itmr_irq #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         expire,
  input  logic         ack,
  input  logic [W-1:0] enable,
  output logic         status,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       status <= 1'b0;
    else if (expire)  status <= 1'b1;
    else if (ack)     status <= 1'b0;
  end

  assign irq = status && (enable != '0);

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> status); // R11
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !expire) |=> !status); // R11
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> !irq); // R12
endmodule

// File: rtl/itmr_top.sv
module itmr_top #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned TICK_DIV = 4,
  parameter int unsigned CLK_HZ   = 100_000_000,
  parameter logic [31:0] DEV_ID   = 32'hC0DE_7100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import itmr_pkg::*;

  localparam int unsigned RATE = CLK_HZ / TICK_DIV;
  localparam int unsigned WIN  = 12;

  logic [IDX_W-1:0]  idx;
  logic              running, single;
  logic [DATA_W-1:0] limit, enable, count;
  logic              tick, expire, status;
  logic              wr_any, new_nz, run_wr, mode_wr, restart, load, ack;
  logic [DATA_W-1:0] load_val;

  assign idx     = bus_addr[WIN-1:2];
  assign wr_any  = bus_we;
  assign new_nz  = (bus_wdata != '0);
  assign run_wr  = wr_any && (idx == IX_RUN) && (new_nz != running);
  assign mode_wr = wr_any && (idx == IX_MODE);
  assign restart = (run_wr && new_nz) || (mode_wr && running);
  assign load    = wr_any && ((idx == IX_LIMIT) || (idx == IX_COUNT));
  assign load_val = bus_wdata;
  assign ack     = wr_any && (idx == IX_STATUS) && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      single  <= 1'b0;
      limit   <= '0;
      enable  <= '0;
    end else begin
      if (run_wr)                    running <= new_nz;
      else if (expire && single)     running <= 1'b0;
      if (mode_wr)                   single  <= new_nz;
      if (wr_any && idx == IX_LIMIT)  limit  <= bus_wdata;
      if (wr_any && idx == IX_ENABLE) enable <= bus_wdata;
    end
  end

  itmr_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(running), .restart(restart), .tick(tick)
  );

  itmr_count #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .single(single), .load(load),
    .load_val(load_val), .limit(limit), .count(count), .expire(expire)
  );

  itmr_irq #(.W(DATA_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .expire(expire), .ack(ack), .enable(enable),
    .status(status), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (idx)
      IX_IDENT:  bus_rdata = DATA_W'(DEV_ID);
      IX_RUN:    bus_rdata = DATA_W'(running);
      IX_MODE:   bus_rdata = DATA_W'(single);
      IX_LIMIT:  bus_rdata = limit;
      IX_COUNT:  bus_rdata = count;
      IX_ENABLE: bus_rdata = enable;
      IX_STATUS: bus_rdata = DATA_W'(status);
      IX_RATE:   bus_rdata = DATA_W'(RATE);
      default:   bus_rdata = '0;
    endcase
  end

  AST_SINGLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && single && !run_wr) |=> !running); // R8
  AST_SAME_RUN_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && idx == IX_RUN && (new_nz == running) && !expire) |=> (running == $past(running))); // R6
  AST_LIMIT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && idx == IX_LIMIT) |=> (limit == count)); // R10
  AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !tick); // R6
endmodule

// File: tb/itmr_top_bench.sv
module itmr_top_bench;
  localparam int    CLK_PERIOD = 10;
  localparam int    DIV   = 4;
  localparam int    HZ    = 100_000_000;
  localparam [31:0] ID    = 32'hC0DE_7100;
  localparam int    I_ID = 0, I_RUN = 1, I_MODE = 2, I_LIM = 3, I_CNT = 4,
                    I_EN = 5, I_ST = 6, I_RATE = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  logic [31:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  itmr_top #(.DATA_W(32), .ADDR_W(12), .TICK_DIV(DIV), .CLK_HZ(HZ), .DEV_ID(ID))
    u_itmr_top (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
                .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic drive(input int ix, input logic we, input logic [31:0] d);
    bus_addr = 12'(ix * 4); bus_we = we; bus_wdata = d;
    @(posedge clk); #2;
    bus_we = 1'b0; bus_addr = 12'(I_CNT * 4);
  endtask

  task automatic wr(input int ix, input logic [31:0] d); drive(ix, 1'b1, d); endtask
  task automatic idle(input int n); for (int k = 0; k < n; k++) drive(I_CNT, 1'b0, 0); endtask

  task automatic rd(input int ix, output logic [31:0] q);
    bus_addr = 12'(ix * 4); #1; q = bus_rdata;
  endtask

  task automatic prep(input int mode, input int lim);
    wr(I_RUN, 0); wr(I_ST, 1); wr(I_MODE, mode); wr(I_EN, 1); wr(I_LIM, lim);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #2;

    // R4 reset state, R2 constants
    rd(I_RUN, v); chk("R4 run", v, 0);
    rd(I_MODE, v); chk("R4 mode", v, 0);
    rd(I_LIM, v); chk("R4 limit", v, 0);
    rd(I_CNT, v); chk("R4 count", v, 0);
    rd(I_EN, v); chk("R4 enable", v, 0);
    rd(I_ST, v); chk("R4 status", v, 0);
    chk("R4 irq", irq, 0);
    rd(I_ID, v); chk("R2 ident", v, ID);
    rd(I_RATE, v); chk("R2 rate", v, HZ / DIV);

    // R2 read-only, R3 unmapped
    wr(I_ID, 32'h1234); wr(I_RATE, 32'h55);
    rd(I_ID, v); chk("R2 ident after write", v, ID);
    rd(I_RATE, v); chk("R2 rate after write", v, HZ / DIV);
    for (int ix = 8; ix < 12; ix++) begin
      wr(ix, 32'hFFFF_FFFF);
      rd(ix, v); chk("R3 unmapped read", v, 0);
    end
    rd(I_LIM, v); chk("R3 limit untouched", v, 0);
    rd(I_EN, v); chk("R3 enable untouched", v, 0);
    rd(I_RUN, v); chk("R3 run untouched", v, 0);

    // R1 low address bits ignored
    bus_addr = 12'(I_LIM * 4 + 3); bus_we = 1'b1; bus_wdata = 32'd77;
    @(posedge clk); #2; bus_we = 1'b0;
    bus_addr = 12'(I_LIM * 4 + 1); #1; chk("R1 offset alias", bus_rdata, 77);

    // R10 limit loads count, count overwrite
    rd(I_CNT, v); chk("R10 limit reloads count", v, 77);
    wr(I_CNT, 32'd300);
    rd(I_CNT, v); chk("R10 count overwrite", v, 300);
    rd(I_LIM, v); chk("R10 limit kept", v, 77);

    // R5 R7 R8 R12 sweeps
    for (int mode = 0; mode < 2; mode++) begin
      for (int lim = 1; lim <= 4; lim++) begin
        prep(mode, lim);
        wr(I_RUN, 1);
        for (int m = 0; m <= 4 * lim * 3; m++) begin
          int j; int exp_c;
          j = m / DIV;
          if (mode == 1) exp_c = (j >= lim) ? 0 : lim - j;
          else           exp_c = lim - (j % lim);
          rd(I_CNT, v);
          chk(mode ? "R8 oneshot count" : "R7 periodic count", v, exp_c);
          chk("R12 irq level", irq, (j >= lim) ? 1 : 0);
          if (m == 3) chk("R5 no decrement before tick", v, lim);
          idle(1);
        end
        rd(I_RUN, v); chk(mode ? "R8 run cleared" : "R7 run kept", v, mode ? 0 : 1);
      end
    end

    // R12 enable gating
    rd(I_ST, v); chk("R11 status set", v, 1);
    wr(I_EN, 0); chk("R12 masked", irq, 0);
    wr(I_EN, 32'h10); chk("R12 any enable bit", irq, 1);
    rd(I_EN, v); chk("R12 enable readback", v, 32'h10);
    wr(I_ST, 0); rd(I_ST, v); chk("R11 zero write keeps", v, 1);
    wr(I_ST, 1); rd(I_ST, v); chk("R11 ack clears", v, 0);
    chk("R12 irq after ack", irq, 0);

    // R6 same-value run write does not restart phase
    prep(0, 10); wr(I_RUN, 1);
    idle(1); wr(I_RUN, 3); idle(6);
    rd(I_CNT, v); chk("R6 same run write no restart", v, 8);
    wr(I_RUN, 0); rd(I_CNT, v);
    idle(12);
    begin logic [31:0] w; rd(I_CNT, w); chk("R6 stop holds count", w, v); end
    rd(I_RUN, v); chk("R6 stopped", v, 0);

    // R9 mode write while running restarts phase
    prep(0, 10); wr(I_RUN, 1);
    idle(1); wr(I_MODE, 1); idle(3);
    rd(I_CNT, v); chk("R9 phase restarted", v, 10);
    idle(1); rd(I_CNT, v); chk("R9 first tick after restart", v, 9);
    rd(I_RUN, v); chk("R9 still running", v, 1);
    idle(40);
    rd(I_CNT, v); chk("R9 new mode oneshot parks", v, 0);
    rd(I_RUN, v); chk("R9 oneshot stopped itself", v, 0);
    wr(I_MODE, 0);
    rd(I_RUN, v); chk("R9 stopped mode write only", v, 0);
    rd(I_MODE, v); chk("R9 mode updated", v, 0);

    // R11 expiry vs ack same edge
    prep(0, 1); wr(I_RUN, 1);
    idle(3); wr(I_ST, 1);
    rd(I_ST, v); chk("R11 set beats ack", v, 1);
    chk("R11 irq kept", irq, 1);
    wr(I_ST, 1); rd(I_ST, v); chk("R11 ack later", v, 0);
    idle(2); rd(I_ST, v); chk("R11 before next expiry", v, 0);
    idle(1); rd(I_ST, v); chk("R11 next expiry", v, 1);

    // R10 load vs tick same edge
    prep(0, 3); wr(I_RUN, 1);
    idle(11); wr(I_CNT, 9);
    rd(I_CNT, v); chk("R10 load beats tick", v, 9);
    rd(I_ST, v); chk("R10 no expiry on load", v, 0);
    idle(4); rd(I_CNT, v); chk("R10 next tick", v, 8);
    wr(I_LIM, 7); rd(I_CNT, v); chk("R10 running limit reload", v, 7);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule